// File: doc/BRIEF.md
# Instruction Fetch and Stall Sequencer

This block sequences instruction fetch and operand access for a small single-issue load/store processor. Instruction fetches and operand accesses share one memory address output. The block holds the program counter and the instruction register, and it decodes the class of the instruction in the register. From that class it chooses the address the memory sees in the current cycle. The memory is expected to return the word for that address by the next rising edge, so the code word sampled at an edge always belongs to the address that was driven during the cycle before it.

A register operation or branch completes in one cycle. A load or store spends its first cycle on the operand address with a read or write strobe, then a second cycle fetching the next instruction. A multiply or divide holds the block in place until the arithmetic unit raises its done strobe. A separate memory-busy stall input freezes everything and takes priority over the other stall. The datapath, register file, arithmetic units and memory sit outside this block.

Top module: `ifetch_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the program counter equals START_ADDR, the instruction register is zero, the memory address equals START_ADDR and both strobes are low.
- R2: In the first cycle after reset, the block fetches at the program counter. At the next edge it captures the code word into the instruction register and does not change the program counter.
- R3: Bits [INSN_W-1:INSN_W-2] of the instruction select its class. The value 00 marks a register operation: the memory address is the program counter plus one (wrapping at ADDR_W bits), and at the next edge that address becomes the program counter and the code word becomes the instruction. The branch-taken input has no effect on this class.
- R4: Class 10 with bit INSN_W-3 clear is a load. In its first cycle the memory address equals the data address and the read strobe is high. In its second cycle the read strobe is low and the address is the program counter plus one. At the end of the second cycle the block advances.
- R5: Class 10 with bit INSN_W-3 set is a store. It follows the same two-cycle pattern as a load but uses the write strobe.
- R6: Class 01 is a multiply or divide. While the done input is low, the program counter and the instruction register hold, and the address stays at the program counter plus one. At the edge where done is sampled high, the block advances.
- R7: Class 11 is a branch. When the branch-taken input is high, the memory address is the branch target and the program counter loads the target. When it is low, the branch behaves like R3.
- R8: While the external stall input is high, the program counter, the instruction register and the phase do not change, so the address and the strobes keep their values.
- R9: When the external stall and the done input are high together, the multiply or divide does not complete. It completes only at a later edge with done high and the stall low.
- R10: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_stall | input | 1 | Memory busy: freeze all state |
| code_word | input | INSN_W | Word returned by memory for the current address |
| data_addr | input | ADDR_W | Operand address computed by the datapath |
| br_target | input | ADDR_W | Branch destination |
| br_taken | input | 1 | Branch condition met (used for class 11 only) |
| md_done | input | 1 | Multiply/divide result ready |
| mem_addr | output | ADDR_W | Shared memory address for this cycle |
| ir | output | INSN_W | Instruction register |
| pc | output | ADDR_W | Address of the instruction in ir |
| rd_stb | output | 1 | Load operand read strobe |
| wr_stb | output | 1 | Store operand write strobe |

## Verification
The bench builds the block with ADDR_W=8, INSN_W=32 and START_ADDR=8'hFC. With these values the short test program runs past address 8'hFF, so the sequential increment wraps to zero inside the multiply wait. The scripted program walks through every instruction class, a taken branch and a not-taken branch. It stalls in the middle of a store and stacks the external stall on top of the multiply wait with done already high, which exercises the stall priority.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_OPER  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    CL_REG    = 2'b00,
    CL_MULDIV = 2'b01,
    CL_MEM    = 2'b10,
    CL_BRANCH = 2'b11
  } iclass_e;

  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_SEQ  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_TGT  = 2'd3
  } addr_sel_e;

endpackage

// File: rtl/ifs_decode.sv
module ifs_decode
  import ifs_pkg::*;
(
  input  logic [2:0] insn_top,
  output iclass_e    cls,
  output logic       is_store
);

  assign cls      = iclass_e'(insn_top[2:1]);
  assign is_store = insn_top[0];

endmodule

// File: rtl/ifs_step_ctl.sv
module ifs_step_ctl
  import ifs_pkg::*;
(
  input  phase_e    phase,
  input  iclass_e   cls,
  input  logic      is_store,
  input  logic      br_taken,
  input  logic      md_done,
  output addr_sel_e sel,
  output logic      capture,
  output logic      advance,
  output phase_e    phase_nx,
  output logic      rd,
  output logic      wr
);

  always_comb begin
    sel      = SEL_SEQ;
    advance  = 1'b0;
    phase_nx = PH_EXEC;
    rd       = 1'b0;
    wr       = 1'b0;
    case (phase)
      PH_FETCH: sel = SEL_PC;
      PH_EXEC: begin
        case (cls)
          CL_REG:    advance = 1'b1;
          CL_MULDIV: advance = md_done;
          CL_MEM: begin
            sel      = SEL_DATA;
            rd       = ~is_store;
            wr       = is_store;
            phase_nx = PH_OPER;
          end
          CL_BRANCH: begin
            sel     = br_taken ? SEL_TGT : SEL_SEQ;
            advance = 1'b1;
          end
          default: advance = 1'b1;
        endcase
      end
      PH_OPER: advance = 1'b1;
      default: begin
        sel      = SEL_PC;
        phase_nx = PH_FETCH;
      end
    endcase
    capture = advance | (phase == PH_FETCH);
  end

endmodule

// File: rtl/ifs_addr_mux.sv
module ifs_addr_mux
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  addr_sel_e         sel,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_next;
  assign pc_next = pc + STEP;

  always_comb begin
    case (sel)
      SEL_PC:   addr = pc;
      SEL_DATA: addr = data_addr;
      SEL_TGT:  addr = br_target;
      default:  addr = pc_next;
    endcase
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifs_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                INSN_W     = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_stall,
  input  logic [INSN_W-1:0] code_word,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              br_taken,
  input  logic              md_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [INSN_W-1:0] ir,
  output logic [ADDR_W-1:0] pc,
  output logic              rd_stb,
  output logic              wr_stb
);

  localparam int TOP_LSB = INSN_W - 3;

  phase_e    phase_q;
  phase_e    phase_nx;
  iclass_e   cls;
  logic      is_store;
  addr_sel_e sel;
  logic      capture;
  logic      advance;

  ifs_decode u_dec (
    .insn_top (ir[INSN_W-1:TOP_LSB]),
    .cls      (cls),
    .is_store (is_store)
  );

  ifs_step_ctl u_ctl (
    .phase    (phase_q),
    .cls      (cls),
    .is_store (is_store),
    .br_taken (br_taken),
    .md_done  (md_done),
    .sel      (sel),
    .capture  (capture),
    .advance  (advance),
    .phase_nx (phase_nx),
    .rd       (rd_stb),
    .wr       (wr_stb)
  );

  ifs_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel       (sel),
    .pc        (pc),
    .data_addr (data_addr),
    .br_target (br_target),
    .addr      (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= START_ADDR;
      ir      <= '0;
      phase_q <= PH_FETCH;
    end else if (!ext_stall) begin
      phase_q <= phase_nx;
      if (capture) ir <= code_word;
      if (advance) pc <= mem_addr;
    end
  end

endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_stall,
  input logic              md_done,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic [ADDR_W-1:0] data_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [INSN_W-1:0] ir,
  input logic              rd_stb,
  input logic              wr_stb,
  input phase_e            phase
);

  logic [1:0] top2;
  assign top2 = ir[INSN_W-1 -: 2];

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    ext_stall |=> ($stable(pc) && $stable(ir) && $stable(phase)));

  assert_md_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && top2 == 2'b01 && !md_done) |=> ($stable(pc) && $stable(ir)));

  assert_branch_load_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && top2 == 2'b11 && br_taken && !ext_stall) |=> (pc == $past(br_target)));

  assert_reg_step_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && top2 == 2'b00 && !ext_stall) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_rd_once_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ext_stall) |=> !rd_stb);

  assert_wr_addr_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (mem_addr == data_addr && top2 == 2'b10 && ir[INSN_W-3]));

endmodule

bind ifetch_seq ifetch_seq_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ext_stall (ext_stall),
  .md_done   (md_done),
  .br_taken  (br_taken),
  .br_target (br_target),
  .data_addr (data_addr),
  .mem_addr  (mem_addr),
  .pc        (pc),
  .ir        (ir),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .phase     (phase_q)
);

// File: tb/sim_ifetch_seq.sv
`timescale 1ns/1ps
module sim_ifetch_seq;

  localparam int          AW    = 8;
  localparam int          IW    = 32;
  localparam logic [7:0]  START = 8'hFC;

  typedef struct {
    logic [AW-1:0] mem;
    logic [AW-1:0] pc;
    logic [IW-1:0] ir;
    logic          rd;
    logic          wr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_stall = 1'b0;
  logic [IW-1:0] code_word;
  logic [AW-1:0] data_addr = '0;
  logic [AW-1:0] br_target = '0;
  logic          br_taken = 1'b0;
  logic          md_done = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [IW-1:0] ir;
  logic [AW-1:0] pc;
  logic          rd_stb;
  logic          wr_stb;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done_run = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] rom(input logic [3:0] idx);
    case (idx)
      4'd0:    return 32'h0000_0001;
      4'd1:    return 32'h8000_0002;
      4'd2:    return 32'hA000_0003;
      4'd3:    return 32'h4000_0004;
      4'd4:    return 32'hC000_0005;
      4'd7:    return 32'h0000_0006;
      4'd8:    return 32'hC000_0007;
      4'd9:    return 32'h0000_0008;
      4'd10:   return 32'h0000_0009;
      default: return 32'h0000_00EE;
    endcase
  endfunction

  assign code_word = rom(4'(mem_addr - START));

  ifetch_seq #(.ADDR_W(AW), .INSN_W(IW), .START_ADDR(START)) u0 (
    .clk(clk), .rst(rst), .ext_stall(ext_stall), .code_word(code_word),
    .data_addr(data_addr), .br_target(br_target), .br_taken(br_taken),
    .md_done(md_done), .mem_addr(mem_addr), .ir(ir), .pc(pc),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  task automatic push(input logic [AW-1:0] m, input logic [AW-1:0] p,
                      input logic [IW-1:0] i, input logic r, input logic w,
                      input string t);
    exp_t e;
    e.mem = m; e.pc = p; e.ir = i; e.rd = r; e.wr = w; e.tag = t;
    q.push_back(e);
  endtask

  task automatic step(input logic st, input logic dn, input logic tk,
                      input logic [AW-1:0] tg, input logic [AW-1:0] da,
                      input logic [AW-1:0] m, input logic [AW-1:0] p,
                      input logic [IW-1:0] i, input logic r, input logic w,
                      input string t);
    @(posedge clk);
    #1;
    rst = 1'b0; ext_stall = st; md_done = dn; br_taken = tk;
    br_target = tg; data_addr = da;
    push(m, p, i, r, w, t);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (mem_addr !== e.mem || pc !== e.pc || ir !== e.ir ||
          rd_stb !== e.rd || wr_stb !== e.wr) begin
        n_fails++;
        $display("FAIL %s: got addr=%h pc=%h ir=%h rd=%b wr=%b, want addr=%h pc=%h ir=%h rd=%b wr=%b",
                 e.tag, mem_addr, pc, ir, rd_stb, wr_stb, e.mem, e.pc, e.ir, e.rd, e.wr);
      end
    end
  end

  initial begin
    @(posedge clk);
    #1;
    push(8'hFC, 8'hFC, 32'h0, 1'b0, 1'b0, "R1 reset");
    //    st   dn   tk   tgt    daddr  addr   pc     ir            rd   wr
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'hFC,8'hFC,32'h0000_0000,1'b0,1'b0,"R1/R2 fetch");
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'hFD,8'hFC,32'h0000_0001,1'b0,1'b0,"R3 reg op");
    step(1'b0,1'b0,1'b0,8'h00,8'h40, 8'h40,8'hFD,32'h8000_0002,1'b1,1'b0,"R4 load operand");
    step(1'b0,1'b0,1'b0,8'h00,8'h40, 8'hFE,8'hFD,32'h8000_0002,1'b0,1'b0,"R4 load second");
    step(1'b1,1'b0,1'b0,8'h00,8'h41, 8'h41,8'hFE,32'hA000_0003,1'b0,1'b1,"R8 stall in store");
    step(1'b0,1'b0,1'b0,8'h00,8'h41, 8'h41,8'hFE,32'hA000_0003,1'b0,1'b1,"R5/R10 store operand");
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'hFF,8'hFE,32'hA000_0003,1'b0,1'b0,"R5 store second");
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'h00,8'hFF,32'h4000_0004,1'b0,1'b0,"R6 md wait");
    step(1'b1,1'b0,1'b0,8'h00,8'h00, 8'h00,8'hFF,32'h4000_0004,1'b0,1'b0,"R8 stall in md");
    step(1'b1,1'b1,1'b0,8'h00,8'h00, 8'h00,8'hFF,32'h4000_0004,1'b0,1'b0,"R9 stall beats done");
    step(1'b0,1'b1,1'b0,8'h00,8'h00, 8'h00,8'hFF,32'h4000_0004,1'b0,1'b0,"R6 md done");
    step(1'b0,1'b0,1'b1,8'h03,8'h00, 8'h03,8'h00,32'hC000_0005,1'b0,1'b0,"R7 taken");
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'h04,8'h03,32'h0000_0006,1'b0,1'b0,"R7 at target");
    step(1'b0,1'b0,1'b0,8'h77,8'h00, 8'h05,8'h04,32'hC000_0007,1'b0,1'b0,"R7 not taken");
    step(1'b0,1'b0,1'b1,8'h77,8'h00, 8'h06,8'h05,32'h0000_0008,1'b0,1'b0,"R3 taken ignored");
    step(1'b0,1'b0,1'b0,8'h00,8'h00, 8'h07,8'h06,32'h0000_0009,1'b0,1'b0,"R3 sequential");
    @(posedge clk);
    @(negedge clk);
    #1;
    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done_run) begin
      n_fails++;
      $display("FAIL watchdog: got running, want finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule